// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer with a small register bank on a 16-bit register bus. A down-counter is decremented once per slow tick. A prescaler derived from the system clock frequency produces that tick, with one tick every 0.6 seconds. Software programs a starting value, releases the halt bit and then keeps the timer alive by writing the reload register. The reload register also reports the live count when it is read.

Expiry has two stages. The first time the counter runs out, the block sets a first-timeout flag, raises an interrupt pulse if interrupts are enabled, and restarts the count. If the counter runs out again before software has cleared that flag, the block sets the second-timeout and boot flags and issues a one-cycle reset request, unless the no-reboot input blocks it. The status flags are cleared by writing one to them.

Top module: `wdt_twostage`

## Requirements
- R1: After reset the halt bit reads 1, the initial value reads 4, the count reads 0, every status flag reads 0, and both outputs are low.
- R2: The initial value is bits [9:0] at address 0x12. A write whose merged low 10 bits are below 4 leaves the stored value unchanged. Bits [15:10] read 0 and are not changed by writes.
- R3: Any write with a non-zero byte enable to address 0x00 loads the count from the initial value and restarts the tick prescaler. A read of 0x00 returns the count in bits [9:0].
- R4: Bit 11 of address 0x08 is the halt bit and reads back its last written value. While it is 1 the count does not change, except through a reload.
- R5: While the counter is running, the count drops by one every PRESCALE clock cycles, where PRESCALE = CLK_HZ*6/10. The first tick comes PRESCALE cycles after a reload or after the halt bit is released.
- R6: On a tick with count 0 and the first-timeout flag (bit 3 of 0x04) clear, the block sets that flag, reloads the count, and drives irq high for exactly one cycle if irq_enable was high. If irq_enable was low, the flag is still set.
- R7: On a tick with count 0 and the first-timeout flag already set, the block sets the second-timeout flag (bit 1 of 0x06) and the boot flag (bit 2 of 0x06), reloads the count, and drives reset_req high for one cycle unless no_reboot was high.
- R8: Writing 1 to a status bit through byte lane 0 clears that bit. Writing 0 leaves it unchanged. If an expiry sets a bit in the same cycle as a clear, the set wins.
- R9: A write with byte enable 0, or a write to an unmapped address, changes no state. Unmapped addresses read 0. Byte lane 1 carries bits [15:8] and lane 0 carries bits [7:0].
- R10: irq and reset_req are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of a 16-bit register |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enables; bit 1 selects [15:8] |
| bus_rdata | output | 16 | Read data, combinational, 0 when not reading |
| no_reboot | input | 1 | Blocks the reset request of the second expiry |
| irq_enable | input | 1 | Allows the interrupt on the first expiry |
| irq | output | 1 | One-cycle interrupt pulse |
| reset_req | output | 1 | One-cycle reset request pulse |

## Verification
The bench goes after the boundaries of the initial value. A design that accepts 3, or one that lets the upper bits land in the field, reads back the wrong value and shortens every later timeout. It checks the exact cycle of each tick and expiry: an off-by-one in the prescaler or in the count-0 compare moves irq by a whole tick. Random clears, reloads and toggles of the gate inputs probe the set-wins rule, the choice between first and second stage, and the masking by no_reboot and irq_enable. A design that got these wrong would reset when it should only interrupt, or would drop a flag that the hardware had just set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned BUS_W  = 16;
    localparam int unsigned ADDR_W = 5;

    // Register byte addresses
    localparam logic [ADDR_W-1:0] ADR_KICK  = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_STA   = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_STB   = 5'h06;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 5'h08;
    localparam logic [ADDR_W-1:0] ADR_START = 5'h12;

    // Bit positions that software relies on
    localparam int unsigned BIT_FIRST  = 3;
    localparam int unsigned BIT_SECOND = 1;
    localparam int unsigned BIT_BOOT   = 2;
    localparam int unsigned BIT_HALT   = 11;

    // Decoded write strobes from the bus
    typedef struct packed {
        logic kick;
        logic halt_wr;
        logic halt_val;
        logic clr_first;
        logic clr_second;
        logic clr_boot;
    } wr_strobe_t;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int unsigned PRESCALE = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] div_d, div_q;

    always_comb begin
        tick  = run && (div_q == LAST);
        div_d = div_q;
        if (!run || restart || tick) begin
            div_d = '0;
        end else begin
            div_d = div_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned MIN_INIT = 4
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [1:0]        bus_be,
    input  logic [CNT_W-1:0]  cur_init,
    output wr_strobe_t        strobe,
    output logic              init_wr,
    output logic [CNT_W-1:0]  init_val
);
    logic wr_any;
    logic [CNT_W-1:0] merged;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign wr_any = bus_valid && bus_write && (bus_be != 2'b00);

    // Per-bit lane merge of the start-value field
    for (genvar i = 0; i < CNT_W; i++) begin : g_merge
        assign merged[i] = bus_be[i / 8] ? bus_wdata[i] : cur_init[i];
    end

    always_comb begin
        strobe = '0;
        init_wr = 1'b0;
        init_val = merged;
        if (wr_any) begin
            unique case (bus_addr)
                ADR_KICK: strobe.kick = 1'b1;
                ADR_START: init_wr = (merged >= CNT_W'(MIN_INIT));
                ADR_CTRL: begin
                    strobe.halt_wr  = bus_be[1];
                    strobe.halt_val = bus_wdata[BIT_HALT];
                end
                ADR_STA: strobe.clr_first = bus_be[0] && bus_wdata[BIT_FIRST];
                ADR_STB: begin
                    strobe.clr_second = bus_be[0] && bus_wdata[BIT_SECOND];
                    strobe.clr_boot   = bus_be[0] && bus_wdata[BIT_BOOT];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wdt_expiry_core.sv
module wdt_expiry_core
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned MIN_INIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_strobe_t       strobe,
    input  logic             init_wr,
    input  logic [CNT_W-1:0] init_val,
    input  logic             tick,
    input  logic             no_reboot,
    input  logic             irq_enable,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] start_val,
    output logic             halt,
    output logic             st_first,
    output logic             st_second,
    output logic             st_boot,
    output logic             irq,
    output logic             reset_req
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] start;
        logic             halt;
        logic             first;
        logic             second;
        logic             boot;
        logic             irq;
        logic             rreq;
    } core_state_t;

    core_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.irq  = 1'b0;
        s_d.rreq = 1'b0;

        if (init_wr)          s_d.start  = init_val;
        if (strobe.halt_wr)   s_d.halt   = strobe.halt_val;
        if (strobe.clr_first) s_d.first  = 1'b0;
        if (strobe.clr_second) s_d.second = 1'b0;
        if (strobe.clr_boot)  s_d.boot   = 1'b0;

        if (strobe.kick) begin
            s_d.count = s_q.start;
        end else if (tick) begin
            if (s_q.count == '0) begin
                s_d.count = s_q.start;
                if (!s_q.first) begin
                    s_d.first = 1'b1;
                    s_d.irq   = irq_enable;
                end else begin
                    s_d.second = 1'b1;
                    s_d.boot   = 1'b1;
                    s_d.rreq   = !no_reboot;
                end
            end else begin
                s_d.count = s_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.start <= CNT_W'(MIN_INIT);
            s_q.halt  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign count     = s_q.count;
    assign start_val = s_q.start;
    assign halt      = s_q.halt;
    assign st_first  = s_q.first;
    assign st_second = s_q.second;
    assign st_boot   = s_q.boot;
    assign irq       = s_q.irq;
    assign reset_req = s_q.rreq;
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned MIN_INIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [1:0]        bus_be,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              no_reboot,
    input  logic              irq_enable,
    output logic              irq,
    output logic              reset_req
);
    // 0.6 s per tick
    localparam int unsigned PRESCALE = (CLK_HZ / 10) * 6 + ((CLK_HZ % 10) * 6) / 10;

    wr_strobe_t       strobe;
    logic             init_wr;
    logic [CNT_W-1:0] init_val;
    logic [CNT_W-1:0] count_w, start_w;
    logic             halt_w, first_w, second_w, boot_w, tick_w, kick_w;

    wdt_bus_decode #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .cur_init  (start_w),
        .strobe    (strobe),
        .init_wr   (init_wr),
        .init_val  (init_val)
    );

    assign kick_w = strobe.kick;

    wdt_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!halt_w),
        .restart (kick_w),
        .tick    (tick_w)
    );

    wdt_expiry_core #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .init_wr    (init_wr),
        .init_val   (init_val),
        .tick       (tick_w),
        .no_reboot  (no_reboot),
        .irq_enable (irq_enable),
        .count      (count_w),
        .start_val  (start_w),
        .halt       (halt_w),
        .st_first   (first_w),
        .st_second  (second_w),
        .st_boot    (boot_w),
        .irq        (irq),
        .reset_req  (reset_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            unique case (bus_addr)
                ADR_KICK:  bus_rdata = BUS_W'(count_w);
                ADR_START: bus_rdata = BUS_W'(start_w);
                ADR_CTRL:  bus_rdata[BIT_HALT] = halt_w;
                ADR_STA:   bus_rdata[BIT_FIRST] = first_w;
                ADR_STB: begin
                    bus_rdata[BIT_SECOND] = second_w;
                    bus_rdata[BIT_BOOT]   = boot_w;
                end
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk #(
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned MIN_INIT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             reset_req,
    input logic             no_reboot,
    input logic             halt,
    input logic             kick,
    input logic             first,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] start_val
);
    AST_START_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        start_val >= CNT_W'(MIN_INIT)); // R2
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !kick) |=> $stable(count)); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !kick) |=> (count == $past(count)) || (count == $past(count) - CNT_W'(1))
                             || (($past(count) == '0) && (count == $past(start_val)))); // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6
    AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> first); // R6
    AST_RESET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(!no_reboot)); // R7
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && reset_req)); // R10
endmodule

bind wdt_twostage wdt_twostage_chk #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .reset_req (reset_req),
    .no_reboot (no_reboot),
    .halt      (halt_w),
    .kick      (kick_w),
    .first     (first_w),
    .count     (count_w),
    .start_val (start_w)
);

// File: tb/test_wdt_twostage.sv
module test_wdt_twostage;
    localparam int unsigned CLK_HZ = 20;      // scaled: 12 cycles per tick
    localparam int unsigned P      = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_rdata;
    logic        no_reboot = 1'b0, irq_enable = 1'b1;
    logic        irq, reset_req;

    int n_chk = 0, n_bad = 0;

    // bench reference state
    logic [9:0] m_count, m_init;
    logic       m_halt, m_first, m_second, m_boot, m_irq, m_rst;
    int         m_presc;

    always #2 clk = ~clk;

    wdt_twostage #(.CLK_HZ(CLK_HZ)) i_wdt_twostage (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .no_reboot(no_reboot), .irq_enable(irq_enable),
        .irq(irq), .reset_req(reset_req)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [4:0] a);
        case (a)
            5'h00:   return 16'(m_count);
            5'h12:   return 16'(m_init);
            5'h08:   return 16'(m_halt) << 11;
            5'h04:   return 16'(m_first) << 3;
            5'h06:   return {13'd0, m_boot, m_second, 1'b0};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string read_tag(input logic [4:0] a);
        case (a)
            5'h00:   return "R5 count";
            5'h12:   return "R2 start value";
            5'h08:   return "R4 halt";
            5'h04:   return "R6 first flag";
            5'h06:   return "R7 second/boot flags";
            default: return "R9 unmapped";
        endcase
    endfunction

    task automatic model_reset();
        m_count = '0; m_init = 10'd4; m_halt = 1'b1;
        m_first = 1'b0; m_second = 1'b0; m_boot = 1'b0;
        m_irq = 1'b0; m_rst = 1'b0; m_presc = 0;
    endtask

    task automatic model_step(input logic v, input logic w, input logic [4:0] a,
                              input logic [15:0] d, input logic [1:0] be);
        logic [9:0] mrg, c_n, i_n;
        logic h_n, f_n, s_n, b_n, irq_n, rst_n_n, tick, kick;
        int p_n;
        tick = !m_halt && (m_presc == P - 1);
        kick = 1'b0;
        c_n = m_count; i_n = m_init; h_n = m_halt;
        f_n = m_first; s_n = m_second; b_n = m_boot; irq_n = 1'b0; rst_n_n = 1'b0;
        if (v && w && be != 2'b00) begin
            case (a)
                5'h00: kick = 1'b1;
                5'h12: begin
                    mrg = m_init;
                    if (be[0]) mrg[7:0] = d[7:0];
                    if (be[1]) mrg[9:8] = d[9:8];
                    if (mrg >= 10'd4) i_n = mrg;
                end
                5'h08: if (be[1]) h_n = d[11];
                5'h04: if (be[0] && d[3]) f_n = 1'b0;
                5'h06: if (be[0]) begin
                    if (d[1]) s_n = 1'b0;
                    if (d[2]) b_n = 1'b0;
                end
                default: ;
            endcase
        end
        p_n = (m_halt || kick || tick) ? 0 : m_presc + 1;
        if (kick) c_n = m_init;
        else if (tick) begin
            if (m_count == 0) begin
                c_n = m_init;
                if (!m_first) begin f_n = 1'b1; irq_n = irq_enable; end
                else begin s_n = 1'b1; b_n = 1'b1; rst_n_n = !no_reboot; end
            end else c_n = m_count - 10'd1;
        end
        m_count = c_n; m_init = i_n; m_halt = h_n; m_first = f_n;
        m_second = s_n; m_boot = b_n; m_irq = irq_n; m_rst = rst_n_n; m_presc = p_n;
    endtask

    // one bus cycle: compare outputs, drive, compare read data, advance model
    task automatic cyc(input logic v, input logic w, input logic [4:0] a,
                       input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        check("R6 irq pulse", 16'(irq), 16'(m_irq));
        check("R7 reset request", 16'(reset_req), 16'(m_rst));
        check("R10 exclusive outputs", 16'(irq & reset_req), 16'h0000);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; bus_be = be;
        #1;
        if (v && !w) check(read_tag(a), bus_rdata, model_read(a));
        model_step(v, w, a, d, be);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 5'h00, 16'h0000, 2'b00);
    endtask

    task automatic rd_lit(input string tag, input logic [4:0] a, input logic [15:0] exp);
        cyc(1'b1, 1'b0, a, 16'h0000, 2'b00);
        check(tag, bus_rdata, exp);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [4:0] a;
        logic [15:0] d;
        void'($urandom(32'd20240613));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd_lit("R1 halt after reset", 5'h08, 16'h0800);
        rd_lit("R1 start after reset", 5'h12, 16'h0004);
        rd_lit("R1 count after reset", 5'h00, 16'h0000);
        rd_lit("R1 flags A after reset", 5'h04, 16'h0000);
        rd_lit("R1 flags B after reset", 5'h06, 16'h0000);

        // R2: too-small value ignored; upper bits not stored
        cyc(1'b1, 1'b1, 5'h12, 16'h0003, 2'b11);
        rd_lit("R2 value 3 ignored", 5'h12, 16'h0004);
        // R9: zero byte enable ignored
        cyc(1'b1, 1'b1, 5'h12, 16'h0009, 2'b00);
        rd_lit("R9 zero enables ignored", 5'h12, 16'h0004);
        cyc(1'b1, 1'b1, 5'h12, 16'hFC06, 2'b11);
        rd_lit("R2 upper bits dropped", 5'h12, 16'h0006);

        // R3: reload loads the start value
        cyc(1'b1, 1'b1, 5'h00, 16'h0001, 2'b01);
        rd_lit("R3 count after kick", 5'h00, 16'h0006);
        // R4: halted count stays put
        idle(40);
        rd_lit("R4 frozen while halted", 5'h00, 16'h0006);

        // release halt: first expiry 7 ticks later
        cyc(1'b1, 1'b1, 5'h08, 16'h0000, 2'b10);
        idle(100);
        rd_lit("R6 first flag set", 5'h04, 16'h0008);
        cyc(1'b1, 1'b1, 5'h04, 16'h0008, 2'b01);
        rd_lit("R8 first flag cleared", 5'h04, 16'h0000);

        // random phase
        for (int k = 0; k < 30000; k++) begin
            if ($urandom % 400 == 0) no_reboot = ~no_reboot;
            if ($urandom % 300 == 0) irq_enable = ~irq_enable;
            if ($urandom % 8 != 0) begin
                idle(1);
                continue;
            end
            case ($urandom % 8)
                0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h06; 3: a = 5'h08;
                4: a = 5'h12; 5: a = 5'h0A; 6: a = 5'h1E; default: a = 5'h00;
            endcase
            d = 16'($urandom);
            if (a == 5'h12) d = {d[15:10], 6'd0, d[3:0]};
            if (a == 5'h08) d[11] = ($urandom % 5 == 0);
            if (a == 5'h00 && $urandom % 3 != 0) begin
                cyc(1'b1, 1'b0, a, 16'h0000, 2'b00);
            end else if ($urandom % 2 == 0) begin
                cyc(1'b1, 1'b0, a, 16'h0000, 2'b00);
            end else begin
                cyc(1'b1, 1'b1, a, d, 2'($urandom));
            end
        end
        idle(2);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule